// File: doc/BRIEF.md
# SPI Slave Serial Engine

This block is the serial half of an SPI slave. The SCK, MOSI and slave-select pins are brought into a faster system clock domain through two-flop synchronizers. SCK edges are detected there, and data is shifted in on MOSI and out on MISO at the same time, one bit per SCK cycle on each line, most significant bit first. The system clock must run at least four times faster than SCK.

At run time, input ports set four things: the clock phase, the SCK edge that launches MISO data, the SCK edge that latches MOSI data, and whether select is active high or active low. The receive and transmit word lengths are also run-time inputs. They are independent of each other and range from 1 to 128 bits. A completed receive word comes out right-aligned with a one-cycle strobe. A transmit word is taken from an upstream buffer whenever the engine pulses its load strobe. MISO is enabled only while the transmit trigger is high. While the enable input is low the engine rests idle, so the configuration inputs can be changed safely.

Top module: `spi_slave_engine`

## Requirements
- R1: With `cpha_i`=0, `tx_data_i` is loaded when select asserts. `tx_load_o` pulses once at that point, and the word's most significant bit is on MISO before the first SCK edge.
- R2: With `cpha_i`=1, no word is loaded at select assertion and MISO reads 0 until the first launch edge. The first launch edge loads `tx_data_i` (pulsing `tx_load_o`) and presents its most significant bit.
- R3: MOSI is captured on the rising SCK edge when `rx_pol_i`=0 and on the falling edge when `rx_pol_i`=1. Bits are taken MSB first. When the programmed number of bits is reached, `rx_data_o` shows the word right-aligned with the upper bits zero, and `rx_valid_o` is high for that cycle.
- R4: MISO moves to the next lower bit on the rising SCK edge when `tx_pol_i`=1 and on the falling edge when `tx_pol_i`=0. With `cpha_i`=0 the last bit is held after it has been sent. With `cpha_i`=1, the launch edge that follows the last bit reloads `tx_data_i` and pulses `tx_load_o`.
- R5: Select is active when `ss_i` equals `ss_pol_i`, so `ss_pol_i`=1 means active high and `ss_pol_i`=0 means active low.
- R6: `rx_len_i` and `tx_len_i` each hold the word length minus one (0 gives 1 bit, 127 gives 128 bits), and the two are used independently.
- R7: `miso_oe_o` is high only while `tx_trig_i` is high and select is active. Whenever `miso_oe_o` is low, `miso_o` is 0.
- R8: While `enable_i` is low, the serial lines have no effect: no word is received, no transmit word is loaded and MISO is not enabled.
- R9: Deasserting select discards any partial receive word. Every select assertion restarts both bit counters.
- R10: `rx_valid_o` never stays high for two cycles in a row, and `rx_data_o` changes only in a cycle where `rx_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable; low holds the engine idle |
| cpha_i | input | 1 | Clock phase |
| tx_pol_i | input | 1 | Launch edge: 1 rising, 0 falling |
| rx_pol_i | input | 1 | Capture edge: 0 rising, 1 falling |
| ss_pol_i | input | 1 | Active level of select |
| rx_len_i | input | CNT_W | Receive length minus one |
| tx_len_i | input | CNT_W | Transmit length minus one |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_i | input | 1 | Slave select from the master |
| tx_trig_i | input | 1 | Transmit trigger; enables MISO |
| tx_data_i | input | MAX_W | Next transmit word, right-aligned |
| tx_load_o | output | 1 | Pulse when tx_data_i is taken |
| rx_data_o | output | MAX_W | Last received word, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO output enable |

## Verification
The assertions are checked on every cycle. They cover the MISO output-enable rules, the quiet state while disabled, the single-cycle receive strobe and the stability of the received word between strobes. Only the bench's scenarios can show the rest. That includes bit order and edge choice in all four clock modes, the different load points for the two phases, and reload across word boundaries in a long phase-1 burst. It also includes independent widths at 1 and 128 bits, and discarding a partial word on deselect. For each of these, the bench compares every MISO bit at the master's sampling point and every received word against its own model.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  parameter int unsigned SPI_MAX_W_DEF = 128;
  parameter int unsigned SPI_SYNC_DEF  = 2;

  typedef struct packed {
    logic clr;
    logic start;
    logic cap;
    logic lau;
  } spi_evt_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
  parameter int unsigned MAX_W = 128,
  parameter int unsigned CNT_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [MAX_W-1:0] word_o,
  output logic             valid_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_W - 1);

  logic [MAX_W-2:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [MAX_W-1:0] nxt, mask;

  assign nxt  = {sh_q, bit_i};
  assign mask = {MAX_W{1'b1}} >> (LAST - len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (cap_i) begin
        sh_q <= nxt[MAX_W-2:0];
        if (cnt_q == len_i) begin
          cnt_q   <= '0;
          word_o  <= nxt & mask;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int unsigned MAX_W = 128,
  parameter int unsigned CNT_W = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             lau_i,
  input  logic             cpha_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [MAX_W-1:0] data_i,
  output logic             bit_o,
  output logic             load_o
);
  logic [MAX_W-1:0] sh_q;
  logic [CNT_W-1:0] idx_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      idx_q   <= '0;
      armed_q <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (clr_i) begin
        idx_q   <= '0;
        armed_q <= 1'b0;
      end else if (start_i) begin
        idx_q <= len_i;
        if (cpha_i) begin
          armed_q <= 1'b1;       // phase 1: load on first launch edge
        end else begin
          sh_q    <= data_i;
          load_o  <= 1'b1;
          armed_q <= 1'b0;
        end
      end else if (lau_i) begin
        if (armed_q) begin
          sh_q    <= data_i;
          idx_q   <= len_i;
          load_o  <= 1'b1;
          armed_q <= 1'b0;
        end else if (idx_q != '0) begin
          idx_q <= idx_q - 1'b1;
        end else if (cpha_i) begin
          sh_q   <= data_i;      // continuous burst: next word
          idx_q  <= len_i;
          load_o <= 1'b1;
        end
      end
    end
  end

  assign bit_o = armed_q ? 1'b0 : sh_q[idx_q];
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine #(
  parameter int unsigned MAX_W       = spi_slave_pkg::SPI_MAX_W_DEF,
  parameter int unsigned SYNC_STAGES = spi_slave_pkg::SPI_SYNC_DEF,
  parameter int unsigned CNT_W       = $clog2(MAX_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cpha_i,
  input  logic             tx_pol_i,
  input  logic             rx_pol_i,
  input  logic             ss_pol_i,
  input  logic [CNT_W-1:0] rx_len_i,
  input  logic [CNT_W-1:0] tx_len_i,
  input  logic             sck_i,
  input  logic             mosi_i,
  input  logic             ss_i,
  input  logic             tx_trig_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_load_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             rx_valid_o,
  output logic             miso_o,
  output logic             miso_oe_o
);
  import spi_slave_pkg::*;

  localparam int unsigned PINS = 3;

  logic [PINS-1:0] pins_raw, pins_syn;
  logic            sck_s, mosi_s, ss_s;
  logic            sck_q, sel_q, sel;
  logic            sck_rise, sck_fall;
  logic            tx_bit;
  spi_evt_t        evt;

  assign pins_raw = {ss_i, mosi_i, sck_i};

  spi_sync #(
    .STAGES (SYNC_STAGES),
    .W      (PINS),
    .RST_VAL(3'b000)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_syn)
  );

  assign sck_s  = pins_syn[0];
  assign mosi_s = pins_syn[1];
  assign ss_s   = pins_syn[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel;
    end
  end

  assign sel      = enable_i & (ss_s == ss_pol_i);
  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  assign evt.clr   = ~sel;
  assign evt.start = sel & ~sel_q;
  assign evt.cap   = sel & (rx_pol_i ? sck_fall : sck_rise);
  assign evt.lau   = sel & (tx_pol_i ? sck_rise : sck_fall);

  spi_rx_path #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (evt.clr),
    .cap_i  (evt.cap),
    .bit_i  (mosi_s),
    .len_i  (rx_len_i),
    .word_o (rx_data_o),
    .valid_o(rx_valid_o)
  );

  spi_tx_path #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (evt.clr),
    .start_i(evt.start),
    .lau_i  (evt.lau),
    .cpha_i (cpha_i),
    .len_i  (tx_len_i),
    .data_i (tx_data_i),
    .bit_o  (tx_bit),
    .load_o (tx_load_o)
  );

  assign miso_oe_o = tx_trig_i & sel;
  assign miso_o    = miso_oe_o & tx_bit;
endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk #(
  parameter int unsigned MAX_W = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             tx_trig_i,
  input logic             tx_load_o,
  input logic [MAX_W-1:0] rx_data_o,
  input logic             rx_valid_o,
  input logic             miso_o,
  input logic             miso_oe_o
);
  assert_oe_needs_trig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> tx_trig_i);

  assert_miso_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);

  assert_oe_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !miso_oe_o);

  assert_disabled_silent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && $past(!enable_i)) |-> (!rx_valid_o && !tx_load_o));

  assert_valid_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_rx_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> $stable(rx_data_o));
endmodule

bind spi_slave_engine spi_slave_engine_chk #(.MAX_W(MAX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .tx_trig_i (tx_trig_i),
  .tx_load_o (tx_load_o),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .miso_o    (miso_o),
  .miso_oe_o (miso_oe_o)
);

// File: tb/spi_slave_engine_tb_top.sv
module spi_slave_engine_tb_top;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, cpha = 1'b0, txp = 1'b0, rxp = 1'b0, ssp = 1'b0;
  logic [6:0]   rx_len = 7'd7, tx_len = 7'd7;
  logic         sck = 1'b0, mosi = 1'b0, ss = 1'b1, trig = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_load, rx_valid, miso, miso_oe;
  logic [W-1:0] rx_data;

  int checks = 0;
  int fails  = 0;
  int loads  = 0;
  logic [W-1:0] exp_q[$];

  always #5 clk = ~clk;

  spi_slave_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .cpha_i(cpha),
    .tx_pol_i(txp), .rx_pol_i(rxp), .ss_pol_i(ssp),
    .rx_len_i(rx_len), .tx_len_i(tx_len),
    .sck_i(sck), .mosi_i(mosi), .ss_i(ss), .tx_trig_i(trig),
    .tx_data_i(tx_data), .tx_load_o(tx_load), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference: received words compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_load) loads++;
      if (rx_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R3", "unexpected rx word", rx_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, "R3", "rx word", rx_data, e);
        end
      end
    end
  end

  task automatic set_ss_pol(input logic p);
    en = 1'b0; ssp = p; ss = ~p;
    wait_n(4);
    en = 1'b1;
    wait_n(2);
  endtask

  task automatic xfer(input bit cph, input bit cpl, input int nclk, input int rw,
                      input int tw, input logic [W-1:0] mw, input logic [W-1:0] tword);
    int ld0, exp_ld;
    cpha = cph; txp = cph ^ cpl; rxp = cph ^ cpl;
    rx_len = 7'(rw - 1); tx_len = 7'(tw - 1); tx_data = tword;
    sck = cpl;
    wait_n(4);
    if (en) begin
      for (int k = 0; k < nclk / rw; k++) begin
        logic [W-1:0] w;
        w = '0;
        for (int j = 0; j < rw; j++) w = {w[W-2:0], mw[nclk-1-(k*rw+j)]};
        exp_q.push_back(w);
      end
    end
    ld0 = loads;
    ss = ssp;
    wait_n(4);
    for (int i = 0; i < nclk; i++) begin
      logic eb, eoe;
      eoe = trig & en;
      if (cph) eb = tword[tw-1-(i % tw)];
      else     eb = (i < tw) ? tword[tw-1-i] : tword[0];
      eb = eb & eoe;
      if (cph) begin
        sck = ~cpl; mosi = mw[nclk-1-i];
        wait_n(4);
      end else begin
        mosi = mw[nclk-1-i];
        wait_n(4);
      end
      check(miso_oe == eoe, "R7", "miso_oe", W'(miso_oe), W'(eoe));
      check(miso == eb, cph ? "R2_R4" : "R1_R4", "miso bit", W'(miso), W'(eb));
      if (cph) begin
        sck = cpl;
        wait_n(4);
      end else begin
        sck = ~cpl;
        wait_n(4);
        sck = cpl;
      end
    end
    wait_n(4);
    ss = ~ssp;
    wait_n(8);
    check(exp_q.size() == 0, "R9", "words outstanding", W'(exp_q.size()), '0);
    exp_q.delete();
    if (!en)      exp_ld = 0;
    else if (cph) exp_ld = (nclk + tw - 1) / tw;
    else          exp_ld = 1;
    check(loads - ld0 == exp_ld, en ? (cph ? "R2" : "R1") : "R8", "tx loads",
          W'(loads - ld0), W'(exp_ld));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", '0, '1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // reset state
    check(!rx_valid && !tx_load, "R10", "strobes after reset", W'({rx_valid, tx_load}), '0);
    check(rx_data == '0, "R3", "rx_data after reset", rx_data, '0);
    check(!miso_oe && !miso, "R7", "miso after reset", W'({miso_oe, miso}), '0);

    trig = 1'b1;
    set_ss_pol(1'b0);                                                // R5 active low
    xfer(1'b0, 1'b0, 8, 8, 8, W'(8'hA5), W'(8'h3C));                 // mode 0, R6
    set_ss_pol(1'b1);                                                // R5 active high
    xfer(1'b1, 1'b0, 32, 16, 16, W'(32'h1234_ABCD), W'(16'hBEEF));   // mode 1 burst
    xfer(1'b0, 1'b1, 8, 8, 8, W'(8'h96), W'(8'hC3));                 // mode 2
    xfer(1'b1, 1'b1, 8, 8, 8, W'(8'h5A), W'(8'h81));                 // mode 3
    // independent widths, R6
    xfer(1'b0, 1'b0, 5, 1, 128, W'(5'b10110), {4'hD, 124'h0});
    xfer(1'b1, 1'b0, 128, 128, 3,
         128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, W'(3'b101));
    // trigger low, R7
    trig = 1'b0;
    xfer(1'b0, 1'b0, 8, 8, 8, W'(8'h71), W'(8'hFF));
    trig = 1'b1;
    // partial discard and counter restart, R9
    xfer(1'b0, 1'b0, 12, 8, 8, W'(12'hC3A), W'(8'h55));
    xfer(1'b0, 1'b0, 8, 8, 8, W'(8'h0F), W'(8'hAA));
    // disabled, R8
    en = 1'b0;
    wait_n(2);
    xfer(1'b0, 1'b0, 8, 8, 8, W'(8'hE7), W'(8'hFF));
    check(!miso_oe, "R8", "oe while disabled", W'(miso_oe), '0);
    en = 1'b1;
    wait_n(4);
    xfer(1'b1, 1'b1, 16, 4, 8, W'(16'h9C2E), W'(8'h6B));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule